// File: doc/BRIEF.md
# Migratory Coherence Home Controller

This block is the home-side controller for a single cache line under a migratory coherence protocol. At most one remote node holds the line at any moment. The home keeps the line's data, the identity of the current owner and, during a hand-over, the identity of the node waiting for the line. Remote nodes reach it through one valid/ready input port. Replies leave through a single-entry output slot, and that slot is the only buffering the block reserves for its answers.

The home has two stable states, Free and Exclusive. It uses a transient Wait state while an invalidate to the current owner is outstanding. When a second node asks for an owned line, the home invalidates the owner and waits for the data to come back. The data can return as an invalidate-data reply, or as a voluntary line return that crossed the invalidate on the way. In either case the data is forwarded to the waiting node, which then becomes the owner. Requests that cannot be served, because the home is busy or because they crossed a home-initiated message, are answered at once with a nack. The number of remote nodes and the data width are parameters.

Top module: `homeMigratory`

## Requirements
- R1: After reset the home is Free with line data zero and no owner, `outValid` is 0 and `inReady` is 1.
- R2: In Free, a request (type 0) from node i produces, one cycle after acceptance, a grant (type 4) to i carrying the current line data, and i becomes owner (Exclusive).
- R3: In Exclusive, a request from a node other than the owner produces an invalidate (type 5) to the owner with zero data, records the requester as pending and enters Wait.
- R4: In Wait, invalidate-data (type 2) from the owner stores its data in the line and produces a grant to the pending node carrying that data; the pending node becomes owner.
- R5: In Exclusive, a line return (type 1) from the owner stores its data, returns the home to Free and produces no output message.
- R6: In Wait, a line return from the owner is taken as the owner's reply: the data is stored and a grant carrying it goes to the pending node, which becomes owner.
- R7: In Wait, a request from any node is answered with a nack (type 6, zero data) to the requester, and the state, owner and pending node are unchanged.
- R8: In Exclusive, a request from the current owner (it crossed a home-initiated message) is answered with a nack to that owner, and the state is unchanged.
- R9: The output slot holds one message: while `outValid` is 1 and `outReady` is 0, `inReady` is 0 and the output fields stay stable; no input is taken during that time.
- R10: Messages that do not fit the state are dropped without output or state change: line returns or invalidate-data from a non-owner, either of them in Free, invalidate-data in Exclusive, and any type code other than 0, 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Incoming message present |
| inReady | output | 1 | Home can accept a message this cycle |
| inType | input | 3 | Incoming type: 0 request, 1 line return, 2 invalidate-data |
| inSrc | input | ID_W | Sending remote node |
| inData | input | DATA_W | Line data carried by returns |
| outValid | output | 1 | Output slot holds a message |
| outReady | input | 1 | Network takes the output message |
| outType | output | 3 | Outgoing type: 4 grant, 5 invalidate, 6 nack |
| outDst | output | ID_W | Destination remote node |
| outData | output | DATA_W | Line data for grants, zero otherwise |

## Verification
On every cycle the assertions check the state moves that follow a request in Free or in Wait, and that a line return from the owner in Exclusive leaves Free without output. They also check that a grant always names the node just recorded as owner, that nothing is accepted while the output slot is occupied, and that a stalled message stays put. The bench scenarios show what no single-cycle property covers: the data carried through a full hand-over, the crossed eviction-against-invalidate race, and nacks that leave the pending hand-over intact. They also show that dropped messages truly leave the line data and owner unchanged, which is only visible through later grants.

// File: rtl/homeMigratoryPkg.sv
package homeMigratoryPkg;

  typedef enum logic [2:0] {
    MSG_REQ   = 3'd0,
    MSG_RET   = 3'd1,
    MSG_IDAT  = 3'd2,
    MSG_GRANT = 3'd4,
    MSG_INV   = 3'd5,
    MSG_NACK  = 3'd6
  } msgKind_e;

  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_EXCL = 2'd1,
    ST_WAIT = 2'd2
  } homeState_e;

  typedef enum logic [1:0] {
    DST_SRC   = 2'd0,
    DST_OWNER = 2'd1,
    DST_PEND  = 2'd2
  } dstSel_e;

  typedef struct packed {
    logic     latchData;
    logic     ownerFromSrc;
    logic     ownerFromPend;
    logic     pendFromSrc;
    logic     sendMsg;
    msgKind_e sendKind;
    dstSel_e  dstSel;
  } strobes_t;

endpackage

// File: rtl/homeCtrl.sv
module homeCtrl
  import homeMigratoryPkg::*;
#(
  parameter int ID_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inFire,
  input  logic [2:0]      inType,
  input  logic [ID_W-1:0] inSrc,
  input  logic [ID_W-1:0] ownerId,
  output strobes_t        strobe
);

  homeState_e state, nextState;
  logic fromOwner;

  assign fromOwner = (inSrc == ownerId);

  always_comb begin
    nextState = state;
    strobe    = '0;
    strobe.sendKind = MSG_NACK;
    strobe.dstSel   = DST_SRC;
    if (inFire) begin
      unique case (state)
        ST_FREE: begin
          if (inType == MSG_REQ) begin
            strobe.sendMsg      = 1'b1;
            strobe.sendKind     = MSG_GRANT;
            strobe.dstSel       = DST_SRC;
            strobe.ownerFromSrc = 1'b1;
            nextState           = ST_EXCL;
          end
        end
        ST_EXCL: begin
          if (inType == MSG_REQ) begin
            strobe.sendMsg = 1'b1;
            if (fromOwner) begin
              strobe.sendKind = MSG_NACK;
              strobe.dstSel   = DST_SRC;
            end else begin
              strobe.sendKind    = MSG_INV;
              strobe.dstSel      = DST_OWNER;
              strobe.pendFromSrc = 1'b1;
              nextState          = ST_WAIT;
            end
          end else if (inType == MSG_RET && fromOwner) begin
            strobe.latchData = 1'b1;
            nextState        = ST_FREE;
          end
        end
        ST_WAIT: begin
          if (inType == MSG_REQ) begin
            strobe.sendMsg  = 1'b1;
            strobe.sendKind = MSG_NACK;
            strobe.dstSel   = DST_SRC;
          end else if ((inType == MSG_RET || inType == MSG_IDAT) && fromOwner) begin
            strobe.latchData     = 1'b1;
            strobe.sendMsg       = 1'b1;
            strobe.sendKind      = MSG_GRANT;
            strobe.dstSel        = DST_PEND;
            strobe.ownerFromPend = 1'b1;
            nextState            = ST_EXCL;
          end
        end
        default: nextState = ST_FREE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_FREE;
    else        state <= nextState;
  end

  assert_free_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FREE && inFire && inType == MSG_REQ) |=> (state == ST_EXCL));

  assert_wait_req_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && inFire && inType == MSG_REQ) |=> (state == ST_WAIT));

  assert_owner_req_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXCL && inFire && inType == MSG_REQ && fromOwner) |=> (state == ST_EXCL));

endmodule

// File: rtl/homeDatapath.sv
module homeDatapath
  import homeMigratoryPkg::*;
#(
  parameter int ID_W   = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobes_t          strobe,
  input  logic [ID_W-1:0]   inSrc,
  input  logic [DATA_W-1:0] inData,
  input  logic              outReady,
  output logic [ID_W-1:0]   ownerId,
  output logic              outValid,
  output logic [2:0]        outType,
  output logic [ID_W-1:0]   outDst,
  output logic [DATA_W-1:0] outData
);

  logic [DATA_W-1:0] lineData;
  logic [ID_W-1:0]   pendId;
  logic [ID_W-1:0]   dstNext;
  logic [DATA_W-1:0] dataNext;

  always_comb begin
    unique case (strobe.dstSel)
      DST_OWNER: dstNext = ownerId;
      DST_PEND:  dstNext = pendId;
      default:   dstNext = inSrc;
    endcase
    if (strobe.sendKind == MSG_GRANT)
      dataNext = strobe.latchData ? inData : lineData;
    else
      dataNext = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lineData <= '0;
      ownerId  <= '0;
      pendId   <= '0;
    end else begin
      if (strobe.latchData)     lineData <= inData;
      if (strobe.ownerFromSrc)  ownerId  <= inSrc;
      if (strobe.ownerFromPend) ownerId  <= pendId;
      if (strobe.pendFromSrc)   pendId   <= inSrc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outType  <= '0;
      outDst   <= '0;
      outData  <= '0;
    end else if (strobe.sendMsg) begin
      outValid <= 1'b1;
      outType  <= strobe.sendKind;
      outDst   <= dstNext;
      outData  <= dataNext;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  assert_stall_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outType) && $stable(outDst) && $stable(outData)));

  assert_grant_to_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.sendMsg && strobe.sendKind == MSG_GRANT) |=> (outDst == ownerId));

endmodule

// File: rtl/homeMigratory.sv
module homeMigratory
  import homeMigratoryPkg::*;
#(
  parameter int NUM_NODES = 4,
  parameter int DATA_W    = 8,
  localparam int ID_W     = (NUM_NODES > 1) ? $clog2(NUM_NODES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  output logic              inReady,
  input  logic [2:0]        inType,
  input  logic [ID_W-1:0]   inSrc,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [2:0]        outType,
  output logic [ID_W-1:0]   outDst,
  output logic [DATA_W-1:0] outData
);

  strobes_t        strobe;
  logic [ID_W-1:0] ownerId;
  logic            inFire;

  assign inReady = !outValid;
  assign inFire  = inValid && inReady;

  homeCtrl #(.ID_W(ID_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .inFire  (inFire),
    .inType  (inType),
    .inSrc   (inSrc),
    .ownerId (ownerId),
    .strobe  (strobe)
  );

  homeDatapath #(.ID_W(ID_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .inSrc    (inSrc),
    .inData   (inData),
    .outReady (outReady),
    .ownerId  (ownerId),
    .outValid (outValid),
    .outType  (outType),
    .outDst   (outDst),
    .outData  (outData)
  );

  assert_no_take_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> !(strobe.sendMsg && $past(outValid)));

  assert_evict_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inFire && inType == MSG_RET && strobe.latchData && !strobe.sendMsg) |=> !outValid);

endmodule

// File: tb/homeMigratory_bench.sv
module homeMigratory_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NODES = 4;
  localparam int DW = 8;

  typedef struct packed {
    logic [2:0]    ty;
    logic [1:0]    src;
    logic [DW-1:0] dat;
    logic          ev;
    logic [2:0]    et;
    logic [1:0]    ed;
    logic [DW-1:0] edat;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 2'd1, 8'h00, 1'b1, 3'd4, 2'd1, 8'h00}, // R2 grant from Free
    '{3'd1, 2'd2, 8'h55, 1'b0, 3'd0, 2'd0, 8'h00}, // R10 return from non-owner
    '{3'd0, 2'd2, 8'h00, 1'b1, 3'd5, 2'd1, 8'h00}, // R3 invalidate owner 1
    '{3'd0, 2'd3, 8'h00, 1'b1, 3'd6, 2'd3, 8'h00}, // R7 nack while waiting
    '{3'd2, 2'd1, 8'h3C, 1'b1, 3'd4, 2'd2, 8'h3C}, // R4 inv-data -> grant 2
    '{3'd0, 2'd2, 8'h00, 1'b1, 3'd6, 2'd2, 8'h00}, // R8 owner request nacked
    '{3'd1, 2'd2, 8'h7E, 1'b0, 3'd0, 2'd0, 8'h00}, // R5 eviction, silent
    '{3'd2, 2'd2, 8'h11, 1'b0, 3'd0, 2'd0, 8'h00}, // R10 inv-data in Free
    '{3'd0, 2'd0, 8'h00, 1'b1, 3'd4, 2'd0, 8'h7E}, // R5 data kept, R2
    '{3'd0, 2'd3, 8'h00, 1'b1, 3'd5, 2'd0, 8'h00}, // R3 invalidate owner 0
    '{3'd1, 2'd0, 8'hA5, 1'b1, 3'd4, 2'd3, 8'hA5}, // R6 crossed eviction
    '{3'd1, 2'd3, 8'h5A, 1'b0, 3'd0, 2'd0, 8'h00}, // R5 eviction to Free
    '{3'd0, 2'd1, 8'h00, 1'b1, 3'd4, 2'd1, 8'h5A}, // R2 grant with 5A
    '{3'd3, 2'd1, 8'hFF, 1'b0, 3'd0, 2'd0, 8'h00}, // R10 unused type
    '{3'd0, 2'd1, 8'h00, 1'b1, 3'd6, 2'd1, 8'h00}  // R8 owner nacked
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [2:0]    inType = '0;
  logic [1:0]    inSrc = '0;
  logic [DW-1:0] inData = '0;
  logic          outValid;
  logic          outReady = 1'b1;
  logic [2:0]    outType;
  logic [1:0]    outDst;
  logic [DW-1:0] outData;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  homeMigratory #(.NUM_NODES(NODES), .DATA_W(DW)) u_homeMigratory (
    .clk(clk), .rst_n(rst_n),
    .inValid(inValid), .inReady(inReady), .inType(inType), .inSrc(inSrc), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outType(outType), .outDst(outDst), .outData(outData)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // drive at a falling edge, accepted at the rising edge, sampled at the next falling edge
  task automatic send(input logic [2:0] t, input logic [1:0] s, input logic [DW-1:0] d);
    @(negedge clk);
    inValid = 1'b1; inType = t; inSrc = s; inData = d;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic expectOut(input string tag, input logic v, input logic [2:0] t,
                           input logic [1:0] d, input logic [DW-1:0] dat);
    chk(tag, "outValid", outValid, v);
    if (v) begin
      chk(tag, "outType", outType, t);
      chk(tag, "outDst", outDst, d);
      chk(tag, "outData", outData, dat);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    doReset();
    chk("R1", "outValid after reset", outValid, 0);
    chk("R1", "inReady after reset", inReady, 1);

    for (int i = 0; i < NV; i++) begin
      send(VECS[i].ty, VECS[i].src, VECS[i].dat);
      expectOut($sformatf("table step %0d", i), VECS[i].ev, VECS[i].et, VECS[i].ed, VECS[i].edat);
    end

    // R9: stalled output slot; state now Exclusive, owner 1, line 5A
    @(negedge clk);
    outReady = 1'b0;
    send(3'd0, 2'd2, 8'h00);
    expectOut("R9 invalidate loaded", 1'b1, 3'd5, 2'd1, 8'h00);
    inValid = 1'b1; inType = 3'd0; inSrc = 2'd3;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9", "inReady while full", inReady, 0);
    expectOut("R9 held", 1'b1, 3'd5, 2'd1, 8'h00);
    inValid = 1'b0;
    outReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R9", "blocked input not taken", outValid, 0);
    send(3'd0, 2'd3, 8'h00);
    expectOut("R7 nack after stall", 1'b1, 3'd6, 2'd3, 8'h00);
    send(3'd2, 2'd1, 8'h99);
    expectOut("R4 pending kept across nack", 1'b1, 3'd4, 2'd2, 8'h99);

    // R1: reset mid-run clears line data and owner
    doReset();
    chk("R1", "outValid after second reset", outValid, 0);
    chk("R1", "inReady after second reset", inReady, 1);
    send(3'd0, 2'd3, 8'h00);
    expectOut("R1 line data zero", 1'b1, 3'd4, 2'd3, 8'h00);
    send(3'd1, 2'd3, 8'h42);
    expectOut("R5 return silent", 1'b0, 3'd0, 2'd0, 8'h00);
    send(3'd0, 2'd2, 8'h00);
    expectOut("R2 grant after return", 1'b1, 3'd4, 2'd2, 8'h42);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule